// File: doc/BRIEF.md
# Banked Clock Divider Selector

This block turns one fast source clock into two divided clocks, at one half and at one quarter of the source rate. Both come from a single two-bit counter, so both have an exact 50% duty cycle whatever the source duty cycle is. Each divided clock rises on the same source edge. Twelve outputs are grouped into four banks of three. A two-bit select code decides how many of the lower banks carry the quarter-rate clock. The highest bank always carries the half-rate clock, and every bank not picked by the code does the same.

An active-low output enable turns the pad drivers on or off for all twelve outputs at once. A bypass input routes the raw source clock to every output. A synchronous clear returns the divider to its phase origin. The select code is sampled only at the end of each quarter-rate period, so a bank changes divider only on a common rising edge and no short pulse appears. A settle flag goes low for a programmable number of source cycles after reset, after an applied select change, after the outputs are re-enabled and after bypass is removed. An event that arrives while the window is running starts the count again.

Top module: `banked_clk_sel`

## Requirements
- R1: The divider phase p counts 0,1,2,3 and wraps on every source edge. The half-rate clock is high when p is even. The quarter-rate clock is high when p is 0 or 1. Both rise together when p wraps from 3 to 0, and p is 0 after reset.
- R2: With applied code c, the number of quarter-rate banks is (c+2) mod 4: 2'b10 gives 0, 2'b11 gives 1, 2'b00 gives 2 and 2'b01 gives 3. These are counted from bank index 0 (clk_out bits 2:0) upward. All other banks carry the half-rate clock.
- R3: Bank index 3 (clk_out bits 11:9) carries the half-rate clock for every select code.
- R4: The three outputs of one bank always carry the same value, bank b on bits 3b to 3b+2.
- R5: While oe_n is 1, out_drv is 0 and clk_out is all zeros. While oe_n is 0, out_drv is 1.
- R6: While test_bypass is 1 and oe_n is 0, every output follows clk_src: high while it is high and low while it is low.
- R7: div_clr sampled high at an edge sets p to 0 at that edge.
- R8: The select input is captured only at an edge where p is 3. The new mapping shows from p = 0 on, and a change at any other phase has no effect until then.
- R9: settle_ok goes low at the edge of any settle event and rises at the SETTLE-th following edge that has no new event. An event inside the window restarts the count. The events are: a capture at p = 3 of a code that differs from the applied one, oe_n going from 1 to 0, and test_bypass going from 1 to 0.
- R10: During reset and after it, settle_ok is 0 until SETTLE edges have passed; the applied code resets to 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel | input | 2 | Bank select code |
| oe_n | input | 1 | Output enable, active low |
| test_bypass | input | 1 | Route source clock straight to outputs |
| div_clr | input | 1 | Synchronous divider clear |
| clk_out | output | 12 | Four banks of three clock outputs |
| out_drv | output | 1 | Pad driver enable for all outputs |
| settle_ok | output | 1 | High once the clock arrangement has settled |

## Verification
The divider phase, the applied select code and the settle counter are all registered. A stimulus applied at one source edge therefore shows in clk_out and settle_ok straight after that edge. The exception is a select change, which waits for the next wrap from phase 3. The output enable and the bypass act combinationally on clk_out and out_drv within the same cycle. The bench drives inputs on falling edges and steps a behavioural phase, select and settle model at each rising edge. It then compares all outputs 2 ns later while the source clock is high. One extra check is made in the low half of the clock to confirm that the bypass follows the clock.

// File: rtl/bclk_pkg.sv
package bclk_pkg;
  localparam int NUM_BANKS = 4;
  localparam int BANK_WIDTH = 3;
  localparam logic [1:0] SEL_RESET = 2'b10;

  // number of low-index banks that carry the quarter-rate clock
  function automatic int unsigned slow_bank_count(input logic [1:0] code);
    case (code)
      2'b10:   return 0;
      2'b11:   return 1;
      2'b00:   return 2;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/bclk_divider.sv
module bclk_divider (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic div2,
  output logic div4,
  output logic wrap
);
  logic [1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) phase_q <= 2'b00;
    else               phase_q <= phase_q + 2'b01;
  end

  // inverted counter bits: both rise on the 3 -> 0 wrap
  assign div2 = ~phase_q[0];
  assign div4 = ~phase_q[1];
  assign wrap = (phase_q == 2'b11);

  p_common_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(div4) && !$past(clr)) |-> $rose(div2))
    else $error("quarter-rate rise without half-rate rise");
endmodule

// File: rtl/bclk_bank_map.sv
module bclk_bank_map
  import bclk_pkg::*;
#(
  parameter int NB = NUM_BANKS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrap,
  input  logic [1:0]    sel,
  output logic [NB-1:0] slow_mask,
  output logic          sel_event
);
  logic [1:0] sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    sel_q <= SEL_RESET;
    else if (wrap) sel_q <= sel;
  end

  assign sel_event = wrap && (sel != sel_q);

  for (genvar b = 0; b < NB; b++) begin : g_mask
    assign slow_mask[b] = (b < slow_bank_count(sel_q)) && (b != NB-1);
  end

  p_sel_at_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> $past(wrap))
    else $error("select applied away from period end");
endmodule

// File: rtl/bclk_settle.sv
module bclk_settle #(
  parameter int SETTLE = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic event_in,
  output logic settled
);
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

  logic [CW-1:0] cnt_q;
  logic          ok_q;

  always_ff @(posedge clk) begin
    if (!rst_n || event_in) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else if (!ok_q) begin
      if (cnt_q == LAST) ok_q  <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign settled = ok_q;

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    event_in |=> (!settled && cnt_q == '0))
    else $error("settle window did not restart");
endmodule

// File: rtl/banked_clk_sel.sv
module banked_clk_sel
  import bclk_pkg::*;
#(
  parameter int NB     = NUM_BANKS,
  parameter int BW     = BANK_WIDTH,
  parameter int SETTLE = 64
) (
  input  logic             clk_src,
  input  logic             rst_n,
  input  logic [1:0]       sel,
  input  logic             oe_n,
  input  logic             test_bypass,
  input  logic             div_clr,
  output logic [NB*BW-1:0] clk_out,
  output logic             out_drv,
  output logic             settle_ok
);
  localparam int NOUT = NB * BW;

  logic          div2, div4, wrap;
  logic [NB-1:0] slow_mask;
  logic          sel_event, reenable_event, unbypass_event, settle_event;
  logic          oe_n_q, test_q;
  logic [NOUT-1:0] bank_clk;

  bclk_divider u_div (
    .clk(clk_src), .rst_n(rst_n), .clr(div_clr),
    .div2(div2), .div4(div4), .wrap(wrap)
  );

  bclk_bank_map #(.NB(NB)) u_map (
    .clk(clk_src), .rst_n(rst_n), .wrap(wrap), .sel(sel),
    .slow_mask(slow_mask), .sel_event(sel_event)
  );

  always_ff @(posedge clk_src) begin
    if (!rst_n) begin
      oe_n_q <= 1'b0;
      test_q <= 1'b0;
    end else begin
      oe_n_q <= oe_n;
      test_q <= test_bypass;
    end
  end

  assign reenable_event = oe_n_q && !oe_n;
  assign unbypass_event = test_q && !test_bypass;
  assign settle_event   = sel_event || reenable_event || unbypass_event;

  bclk_settle #(.SETTLE(SETTLE)) u_settle (
    .clk(clk_src), .rst_n(rst_n), .event_in(settle_event), .settled(settle_ok)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign bank_clk[b*BW +: BW] = {BW{slow_mask[b] ? div4 : div2}};
  end

  assign out_drv = !oe_n;
  assign clk_out = oe_n        ? '0 :
                   test_bypass ? {NOUT{clk_src}} : bank_clk;

  p_hiz_r5: assert property (@(posedge clk_src) disable iff (!rst_n)
    oe_n |-> (!out_drv && clk_out == '0))
    else $error("outputs driven while disabled");

  p_top_bank_toggles_r3: assert property (@(posedge clk_src) disable iff (!rst_n)
    (!oe_n && !test_bypass && $past(rst_n && !oe_n && !test_bypass && !div_clr))
    |-> (clk_out[NOUT-1] != $past(clk_out[NOUT-1])))
    else $error("top bank not at half rate");
endmodule

// File: tb/banked_clk_sel_test.sv
module banked_clk_sel_test;
  localparam int SETTLE = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  sel = 2'b10;
  logic        oe_n = 1'b0;
  logic        test_bypass = 1'b0;
  logic        div_clr = 1'b0;
  logic [11:0] clk_out;
  logic        out_drv, settle_ok;

  int n_chk = 0, n_fail = 0;
  string req = "R10";

  always #4 clk = ~clk;

  banked_clk_sel #(.SETTLE(SETTLE)) uut (
    .clk_src(clk), .rst_n(rst_n), .sel(sel), .oe_n(oe_n),
    .test_bypass(test_bypass), .div_clr(div_clr),
    .clk_out(clk_out), .out_drv(out_drv), .settle_ok(settle_ok)
  );

  // behavioural reference
  int ph, selq_m, sc;
  bit ok_m, oe_prev, test_prev, ev;
  logic [11:0] exp_out;

  function automatic logic [11:0] expected_banks(int phase, int code);
    logic [11:0] v;
    int nslow;
    nslow = (code + 2) % 4;
    for (int b = 0; b < 4; b++) begin
      logic bit_v;
      bit_v = (b < nslow) ? (phase < 2) : (phase % 2 == 0);
      for (int k = 0; k < 3; k++) v[b*3+k] = bit_v;
    end
    return v;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (!rst_n) begin
        ph = 0; selq_m = 2; sc = 0; ok_m = 0; oe_prev = 0; test_prev = 0;
      end else begin
        ev = (ph == 3 && int'(sel) != selq_m) || (oe_prev && !oe_n) || (test_prev && !test_bypass);
        if (ph == 3) selq_m = int'(sel);
        ph = div_clr ? 0 : (ph + 1) % 4;
        oe_prev = oe_n; test_prev = test_bypass;
        if (ev) begin sc = 0; ok_m = 0; end
        else if (!ok_m) begin
          if (sc == SETTLE - 1) ok_m = 1; else sc++;
        end
      end
      #2;
      exp_out = oe_n ? 12'h000 : (test_bypass ? 12'hFFF : expected_banks(ph, selq_m));
      check(req, "clk_out", int'(clk_out), int'(exp_out));
      check(oe_n ? "R5" : req, "out_drv", int'(out_drv), int'(!oe_n));
      check(req == "R10" ? "R10" : "R9", "settle_ok", int'(settle_ok), int'(ok_m));
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    run(3);
    rst_n = 1'b1;
    run(70);                       // R10, R9 initial window, R3 banks all half rate
    req = "R2"; sel = 2'b11; run(20);
    sel = 2'b00; run(20);
    sel = 2'b01; run(80);          // R2, R4 over settled period
    req = "R8"; run(1); sel = 2'b10; run(1); sel = 2'b01; run(12); // mid-period glitch of select
    req = "R7"; run(1); div_clr = 1'b1; run(1); div_clr = 1'b0; run(10);
    div_clr = 1'b1; run(3); div_clr = 1'b0; run(10);
    req = "R5"; oe_n = 1'b1; run(8);
    req = "R9"; oe_n = 1'b0; run(30);
    sel = 2'b11; run(30);          // restart inside window
    run(50);
    req = "R6"; test_bypass = 1'b1; run(6);
    #2 check("R6", "clk_out low phase", int'(clk_out), 0);
    run(4);
    req = "R9"; test_bypass = 1'b0; run(70);
    req = "R3"; sel = 2'b01; run(20); sel = 2'b10; run(20);
    req = "R10"; rst_n = 1'b0; run(3); rst_n = 1'b1; run(68);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule